// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects interrupt requests on a parameterised set of input lines (eight by default) and presents the most urgent one to a processor. A request is captured when its line goes from low to high. A per-line mask keeps a captured request from being forwarded. Line 0 has the highest priority, and the priority of each higher-numbered line is lower than the one before it. A line that is in service blocks every line of equal or lower priority. A line of higher priority can still raise the interrupt output, so handlers can nest.

The processor answers the interrupt output with a one-cycle acknowledge pulse. In that same cycle the controller returns a vector, which is the programmed offset plus the line number. It also moves the request into the in-service register. Software later retires the line with an end-of-interrupt command.

The processor reaches the controller through two addresses:
- **Command address** (addr = 0): carries the initialisation start, end-of-interrupt and readback-select commands.
- **Data address** (addr = 1): carries the initialisation words and mask writes, and returns the selected register on reads.

Top module: `pic_vector_ctrl`

## Requirements
- R1: After reset the request and in-service registers are zero, the mask is all ones, the interrupt output is low, the readback selects the request register, and the controller waits for initialisation.
- R2: Writing 0x11 to the command address (addr=0) starts initialisation. The next three data-address (addr=1) writes are taken as vector offset, cascade word and mode word, and none of them changes the mask. The interrupt output stays low until the third word has been written.
- R3: A data-address write outside initialisation loads the mask. A set mask bit keeps its line from raising the interrupt output, and 0xFF silences every line.
- R4: A rising edge on a request line sets its request bit. The bit is cleared when that line is acknowledged or when the line falls before acknowledge.
- R5: Among the unmasked pending requests, the lowest line number wins.
- R6: On an acknowledge cycle with a winner, the vector output equals offset plus the winning line number (modulo 256) in that same cycle, the winner's request bit clears and its in-service bit sets.
- R7: The interrupt output is high exactly when the controller is initialised and an unmasked pending line has a lower number than every in-service line.
- R8: Writing 0x20 to the command address clears the in-service bit of the lowest-numbered line in service.
- R9: Writing 0x0A to the command address selects the request register for data-address reads, and writing 0x0B selects the in-service register. Reads are combinational.
- R10: An acknowledge with no winner returns offset plus 7 (the last line) and leaves the in-service register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | 8 | Request lines, captured on rising edge |
| wrEn | input | 1 | Register write strobe |
| addr | input | 1 | 0 = command address, 1 = data address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Data-address read value (request or in-service register) |
| inta | input | 1 | One-cycle interrupt acknowledge |
| intOut | output | 1 | Interrupt request to the processor |
| vectorOut | output | 8 | Vector returned during acknowledge |

## Verification
The bench builds the block with its defaults: eight lines and 8-bit data. With these values, offset plus line number stays inside one byte for the offsets used. The spurious vector, offset plus 7, can be checked against the last line directly.

Directed sequences cover the following cases:
- initialisation words leaving the mask untouched
- a nested acknowledge under a lower line in service
- end-of-interrupt ordering
- a request that vanishes before acknowledge

A long random phase then mixes the following against a bench model:
- line toggles
- acknowledges
- mask writes
- end-of-interrupt commands
- readback selects
- occasional re-initialisation

// File: rtl/pic_pkg.sv
`timescale 1ns/1ps
package pic_pkg;
  localparam logic [7:0] CMD_INIT   = 8'h11;
  localparam logic [7:0] CMD_EOI    = 8'h20;
  localparam logic [7:0] CMD_RD_REQ = 8'h0A;
  localparam logic [7:0] CMD_RD_ISV = 8'h0B;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OFFSET, ST_CASCADE, ST_MODE, ST_READY
  } ctrlState_t;

  typedef struct packed {
    logic loadOffset;
    logic loadMask;
    logic eoi;
    logic selIsv;
    logic ready;
  } ctrlBus_t;
endpackage

// File: rtl/pic_ctrl.sv
`timescale 1ns/1ps
module pic_ctrl
  import pic_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              addr,
  input  logic [DATA_W-1:0] wrData,
  output ctrlBus_t          ctl
);
  ctrlState_t state, stateNext;
  logic selIsv, selIsvNext;
  logic cmdWr, dataWr;

  assign cmdWr  = wrEn && !addr;
  assign dataWr = wrEn && addr;

  always_comb begin
    stateNext  = state;
    selIsvNext = selIsv;
    if (cmdWr) begin
      if (wrData[7:0] == CMD_INIT) stateNext = ST_OFFSET;
      else if (wrData[7:0] == CMD_RD_REQ) selIsvNext = 1'b0;
      else if (wrData[7:0] == CMD_RD_ISV) selIsvNext = 1'b1;
    end else if (dataWr) begin
      case (state)
        ST_OFFSET:  stateNext = ST_CASCADE;
        ST_CASCADE: stateNext = ST_MODE;
        ST_MODE:    stateNext = ST_READY;
        default:    stateNext = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      selIsv <= 1'b0;
    end else begin
      state  <= stateNext;
      selIsv <= selIsvNext;
    end
  end

  always_comb begin
    ctl.loadOffset = dataWr && (state == ST_OFFSET);
    ctl.loadMask   = dataWr && (state == ST_IDLE || state == ST_READY);
    ctl.eoi        = cmdWr && (wrData[7:0] == CMD_EOI);
    ctl.selIsv     = selIsv;
    ctl.ready      = (state == ST_READY);
  end

  AST_MODE_TO_READY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_MODE && dataWr && !cmdWr) |=> ctl.ready);  // R2
  AST_INIT_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && wrData[7:0] == CMD_INIT) |=> !ctl.ready);  // R2
endmodule

// File: rtl/pic_datapath.sv
`timescale 1ns/1ps
module pic_datapath
  import pic_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int DATA_W    = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqIn,
  input  logic                 inta,
  input  logic [DATA_W-1:0]    wrData,
  input  ctrlBus_t             ctl,
  output logic                 intOut,
  output logic [DATA_W-1:0]    vectorOut,
  output logic [DATA_W-1:0]    rdData
);
  localparam int IDX_W = $clog2(NUM_LINES);
  localparam logic [IDX_W:0] NONE = (IDX_W+1)'(NUM_LINES);
  localparam logic [DATA_W-1:0] LAST_LINE = DATA_W'(NUM_LINES - 1);

  logic [NUM_LINES-1:0] reqReg, isvReg, maskReg, irqPrev;
  logic [DATA_W-1:0]    offsetReg;
  logic [NUM_LINES-1:0] pending, ackSet, eoiClr;
  logic [IDX_W:0]       winPos, blkPos;
  logic [IDX_W-1:0]     winIdx;
  logic                 winValid, ackHit;

  function automatic logic [IDX_W:0] lowestSet(input logic [NUM_LINES-1:0] v);
    logic [IDX_W:0] r;
    r = NONE;
    for (int i = NUM_LINES - 1; i >= 0; i--)
      if (v[i]) r = (IDX_W+1)'(i);
    return r;
  endfunction

  assign pending  = reqReg & ~maskReg;
  assign winPos   = lowestSet(pending);
  assign blkPos   = lowestSet(isvReg);
  assign winValid = ctl.ready && (winPos != NONE) && (winPos < blkPos);
  assign winIdx   = winPos[IDX_W-1:0];
  assign ackHit   = inta && winValid;
  assign intOut   = winValid;

  always_comb begin
    ackSet = '0;
    eoiClr = '0;
    if (ackHit) ackSet[winIdx] = 1'b1;
    if (ctl.eoi && blkPos != NONE) eoiClr[blkPos[IDX_W-1:0]] = 1'b1;
  end

  assign vectorOut = offsetReg + (winValid ? DATA_W'(winIdx) : LAST_LINE);
  assign rdData    = ctl.selIsv ? DATA_W'(isvReg) : DATA_W'(reqReg);

  generate
    for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
      always_ff @(posedge clk) begin
        if (!rstN) begin
          reqReg[g]  <= 1'b0;
          irqPrev[g] <= 1'b0;
        end else begin
          irqPrev[g] <= irqIn[g];
          if (ackSet[g])                    reqReg[g] <= 1'b0;
          else if (irqIn[g] && !irqPrev[g]) reqReg[g] <= 1'b1;
          else if (!irqIn[g])               reqReg[g] <= 1'b0;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      isvReg    <= '0;
      maskReg   <= '1;
      offsetReg <= '0;
    end else begin
      isvReg <= (isvReg | ackSet) & ~eoiClr;
      if (ctl.loadMask)   maskReg   <= wrData[NUM_LINES-1:0];
      if (ctl.loadOffset) offsetReg <= wrData;
    end
  end

  AST_INT_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    intOut |-> (|(reqReg & ~maskReg)));  // R7
  AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (&maskReg) |-> !intOut);  // R3
  AST_ACK_SETS_ISV: assert property (@(posedge clk) disable iff (!rstN)
    (inta && intOut) |=> isvReg[$past(winIdx)]);  // R6
  AST_SPURIOUS_NO_ISV: assert property (@(posedge clk) disable iff (!rstN)
    (inta && !intOut && !ctl.eoi) |=> $stable(isvReg));  // R10
  AST_EOI_DROPS_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.eoi && !inta && (|isvReg)) |=>
      ($countones(isvReg) + 1 == $countones($past(isvReg))));  // R8
  AST_NOT_READY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.ready |-> !intOut);  // R2
endmodule

// File: rtl/pic_vector_ctrl.sv
`timescale 1ns/1ps
module pic_vector_ctrl
  import pic_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int DATA_W    = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqIn,
  input  logic                 wrEn,
  input  logic                 addr,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  input  logic                 inta,
  output logic                 intOut,
  output logic [DATA_W-1:0]    vectorOut
);
  ctrlBus_t ctl;

  pic_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .ctl(ctl)
  );

  pic_datapath #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .inta(inta), .wrData(wrData),
    .ctl(ctl), .intOut(intOut), .vectorOut(vectorOut), .rdData(rdData)
  );
endmodule

// File: tb/pic_vector_ctrl_tb.sv
`timescale 1ns/1ps
module pic_vector_ctrl_tb_top;
  logic clk = 1'b0;
  logic rstN;
  logic [7:0] irqIn;
  logic wrEn, addr, inta;
  logic [7:0] wrData;
  logic [7:0] rdData, vectorOut;
  logic intOut;
  int checks = 0;
  int errors = 0;

  logic [7:0] mReq, mIsv, mMask, mOff, mPrev;
  logic mSel;
  int mStep;   // 0 idle,1 offset,2 cascade,3 mode,4 ready

  always #2.5 clk = ~clk;

  pic_vector_ctrl dut_i (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .inta(inta), .intOut(intOut),
    .vectorOut(vectorOut)
  );

  function automatic int lowestSet(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    mReq = 0; mIsv = 0; mMask = 8'hFF; mOff = 0; mPrev = 0; mSel = 0; mStep = 0;
  endtask

  task automatic cycle(input string tag, input logic [7:0] irq, input logic wr,
                       input logic ad, input logic [7:0] d, input logic ack);
    int w, b;
    logic v;
    logic [7:0] rise, setB, clrB, nReq;
    @(negedge clk);
    irqIn = irq; wrEn = wr; addr = ad; wrData = d; inta = ack;
    #1;
    w = lowestSet(mReq & ~mMask);
    b = lowestSet(mIsv);
    v = (mStep == 4) && (w < 8) && (w < b);
    chk({tag, " intOut"}, {7'b0, intOut}, {7'b0, v});
    if (ack) begin
      if (v) chk("R6 vector", vectorOut, mOff + 8'(w));
      else   chk("R10 spurious vector", vectorOut, mOff + 8'd7);
    end
    chk("R9 readback", rdData, mSel ? mIsv : mReq);
    // model the coming clock edge
    rise = irq & ~mPrev;
    setB = 0; clrB = 0;
    if (ack && v) setB[w] = 1'b1;
    if (wr && !ad && d == 8'h20 && b < 8) clrB[b] = 1'b1;
    for (int i = 0; i < 8; i++) begin
      nReq[i] = setB[i] ? 1'b0 : (rise[i] ? 1'b1 : (!irq[i] ? 1'b0 : mReq[i]));
    end
    mReq = nReq;
    mIsv = (mIsv | setB) & ~clrB;
    mPrev = irq;
    if (wr && !ad) begin
      if (d == 8'h11) mStep = 1;
      else if (d == 8'h0A) mSel = 0;
      else if (d == 8'h0B) mSel = 1;
    end else if (wr && ad) begin
      case (mStep)
        1: begin mOff = d; mStep = 2; end
        2: mStep = 3;
        3: mStep = 4;
        default: mMask = d;
      endcase
    end
  endtask

  task automatic idle(input string tag, input logic [7:0] irq);
    cycle(tag, irq, 1'b0, 1'b0, 8'h00, 1'b0);
  endtask
  task automatic cmd(input string tag, input logic [7:0] irq, input logic [7:0] d);
    cycle(tag, irq, 1'b1, 1'b0, d, 1'b0);
  endtask
  task automatic dat(input string tag, input logic [7:0] irq, input logic [7:0] d);
    cycle(tag, irq, 1'b1, 1'b1, d, 1'b0);
  endtask
  task automatic ack(input string tag, input logic [7:0] irq);
    cycle(tag, irq, 1'b0, 1'b0, 8'h00, 1'b1);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] irq;
    void'($urandom(32'h5EED));
    rstN = 0; irqIn = 0; wrEn = 0; addr = 0; wrData = 0; inta = 0;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state seen at the ports
    idle("R1", 8'h00);
    chk("R1 rdData after reset", rdData, 8'h00);
    // R2: requests before initialisation stay silent
    idle("R2", 8'h01);
    idle("R2", 8'h01);
    cmd("R2", 8'h01, 8'h11);
    dat("R2", 8'h01, 8'h20);
    dat("R2", 8'h01, 8'h04);
    dat("R2", 8'h01, 8'h01);
    idle("R2 mask untouched by init", 8'h01);
    // R3: mask write opens line 0
    dat("R3", 8'h01, 8'hFE);
    idle("R3 unmasked", 8'h01);
    // R5/R6: lines 0 and 3, line 0 wins
    idle("R4", 8'h09);
    ack("R6", 8'h09);
    dat("R3", 8'h09, 8'h00);
    idle("R7 blocked by in-service 0", 8'h09);
    cmd("R8", 8'h09, 8'h20);
    idle("R8 after eoi", 8'h09);
    ack("R6", 8'h09);
    // R7: nesting, line 1 above line 3 in service
    idle("R7", 8'h0B);
    ack("R7 nested", 8'h0B);
    cmd("R9", 8'h0B, 8'h0B);
    idle("R9 isv readback", 8'h0B);
    chk("R9 isv value", rdData, 8'h0A);
    cmd("R8", 8'h0B, 8'h20);
    idle("R8", 8'h0B);
    chk("R8 lowest cleared first", rdData, 8'h08);
    cmd("R8", 8'h0B, 8'h20);
    cmd("R9", 8'h00, 8'h0A);
    // R4/R10: request vanishes before acknowledge
    idle("R4", 8'h20);
    idle("R4 pending", 8'h20);
    idle("R4 dropped", 8'h00);
    ack("R10", 8'h00);
    cmd("R9", 8'h00, 8'h0B);
    idle("R10 isv unchanged", 8'h00);
    cmd("R9", 8'h00, 8'h0A);
    // R5: lines 6 and 2 together
    idle("R5", 8'h44);
    ack("R5", 8'h44);
    cmd("R8", 8'h44, 8'h20);
    // R3: everything masked
    idle("R3", 8'h00);
    idle("R3", 8'h10);
    dat("R3", 8'h10, 8'hFF);
    idle("R3 all masked", 8'h10);
    dat("R3", 8'h10, 8'h00);
    // random phase
    irq = 8'h10;
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if ($urandom_range(0, 3) == 0) irq = irq ^ 8'($urandom_range(0, 255));
      if (r < 25)      ack("R5 random", irq);
      else if (r < 35) cmd("R8 random", irq, 8'h20);
      else if (r < 40) cmd("R9 random", irq, ($urandom_range(0, 1) != 0) ? 8'h0B : 8'h0A);
      else if (r < 45) dat("R3 random", irq, 8'($urandom_range(0, 255)) & 8'hF7);
      else if (r < 46) cmd("R2 random", irq, 8'h11);
      else             idle("R7 random", irq);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule